// File: doc/BRIEF.md
# Graphic LCD Command and Display-RAM Access Controller

This block connects an 8-bit microprocessor bus to a single-port dot-matrix display memory of 4 pages by 80 columns of bytes. Each byte in a page holds 8 vertically stacked dots, so the memory holds 2560 bits. The processor writes one-byte instructions that set the page, the column, the first display line and a handful of panel mode flags. It then streams display bytes in or out through an auto-incrementing column counter, and it can poll a status byte.

The bus strobes are asynchronous to the block's system clock. They pass through a synchronizer, and each access takes effect when its strobe ends. Two strobe styles are supported. In the first, an active-high enable is qualified by a read/write level. In the second, separate active-low read and write strobes are used. The style is the level of `style_sel` while reset is held.

Display reads go through a one-deep prefetch latch. A read returns the byte fetched by the previous read and then fetches from the current address, so software issues one discarded read after moving the address. The bus is a strobe protocol and has no valid/ready handshake. The block never stalls the processor. Instead, it reports BUSY, and software polls that bit.

Top module: `glcd_lcd_ctrl`

## Requirements
- R1: The strobe style is latched while `rst_n` is low. With `style_sel`=1, `bus_e_rd` high marks an access and `bus_rw_wr`=1 makes it a read. With `style_sel`=0, `bus_e_rd` low marks a read and `bus_rw_wr` low marks a write. An access takes effect when its strobe ends.
- R2: With `bus_a0`=1 the access moves display data. With `bus_a0`=0 a write is an instruction and a read returns the status byte.
- R3: Instruction `0b0ccccccc` sets the column, and a value above 79 is clamped to 79. Instruction `0b101110pp` sets the page (0..3). The memory address is {page, column}, with the page in `ram_addr[8:7]` and the column in `ram_addr[6:0]`.
- R4: A data write stores the bus byte at the current address. A data read returns the prefetch latch, then refills the latch from the current address. Either access then advances the column by one. The first read after an address change therefore returns stale data.
- R5: The column counter wraps from 79 to 0 and leaves the page unchanged.
- R6: Instruction 0xE0 enters read-modify-write mode. In that mode data reads leave the column unchanged and data writes still advance it. Instruction 0xEE returns to normal advance on both.
- R7: The status byte is {BUSY, segment reverse, display off, reset window, 4'b0000}, from bit 7 down to bit 0.
- R8: 0xAF turns the display on and 0xAE turns it off (`lcd_off`=1 means off). 0xC0|n sets the start line n (0..31). 0xA0/0xA1 clears or sets segment reverse, 0xA4/0xA5 clears or sets static drive, and 0xA8/0xA9 selects 1/16 or 1/32 duty. Other codes are ignored.
- R9: BUSY stays high for BUSY_CYCLES clocks after reset and after each data access. Instruction writes that end while BUSY is high are ignored. Data accesses are always accepted.
- R10: Instruction 0xE2 sets the start line, page and column to 0 and leaves the mode flags unchanged.
- R11: After reset the display is off, start line, page and column are 0, all other flags are 0, the prefetch latch is 0, and the reset-window status bit is 1 until BUSY first clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| style_sel | input | 1 | Strobe style, sampled while reset is held (1: enable + read/write, 0: separate read/write strobes) |
| bus_a0 | input | 1 | Data (1) or instruction/status (0) select |
| bus_e_rd | input | 1 | Enable (style 1) or active-low read strobe (style 0) |
| bus_rw_wr | input | 1 | Read/write level (style 1) or active-low write strobe (style 0) |
| bus_din | input | 8 | Byte from the processor |
| bus_dout | output | 8 | Byte to the processor, 0 when not driven |
| bus_dout_en | output | 1 | High while a read strobe is active |
| ram_en | output | 1 | One-cycle memory access pulse |
| ram_we | output | 1 | Write qualifier for `ram_en` |
| ram_addr | output | 9 | {page, column} |
| ram_wdata | output | 8 | Write byte |
| ram_rdata | input | 8 | Read byte, valid one clock after `ram_en` |
| lcd_off | output | 1 | Display blanked |
| lcd_start_line | output | 5 | Memory line shown on the top row |
| lcd_seg_rev | output | 1 | Reverse column-to-segment order |
| lcd_static | output | 1 | Static all-on drive |
| lcd_duty32 | output | 1 | 1/32 duty when set, 1/16 when clear |

## Verification
The bench writes with a column value above 79 and then reads back at column 79. A design without the clamp would write elsewhere, and the check would read 0. It writes across column 79 and reads column 0 of the same page, so a design that carried the wrap into the page would lose the byte. It follows a read-modify-write sequence with END and then a further read. A design that advanced on reads in that mode, or that stayed in the mode after END, would return the wrong prefetched bytes. It also sends a column instruction immediately after a data write and checks that the next write lands at the old column, which exposes a design that accepted instructions while busy. Finally, it repeats an access under the second strobe style after a fresh reset.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  typedef struct packed {
    logic       rd;
    logic       data;
    logic [7:0] val;
  } bus_evt_t;

  typedef enum logic [3:0] {
    K_NONE, K_COL, K_PAGE, K_LINE, K_DISP, K_SEG,
    K_STATIC, K_DUTY, K_RMW, K_END, K_RESET
  } op_kind_e;

  localparam logic [7:0] OP_RMW_ON  = 8'hE0;
  localparam logic [7:0] OP_RMW_OFF = 8'hEE;
  localparam logic [7:0] OP_HOME    = 8'hE2;

  function automatic op_kind_e decode_op(input logic [7:0] b);
    if (b[7] == 1'b0)                 return K_COL;
    else if (b[7:5] == 3'b110)        return K_LINE;
    else if (b[7:2] == 6'b101110)     return K_PAGE;
    else if (b[7:1] == 7'b1010111)    return K_DISP;
    else if (b[7:1] == 7'b1010000)    return K_SEG;
    else if (b[7:1] == 7'b1010010)    return K_STATIC;
    else if (b[7:1] == 7'b1010100)    return K_DUTY;
    else if (b == OP_RMW_ON)          return K_RMW;
    else if (b == OP_RMW_OFF)         return K_END;
    else if (b == OP_HOME)            return K_RESET;
    else                              return K_NONE;
  endfunction

endpackage

// File: rtl/glcd_bus_sync.sv
module glcd_bus_sync
  import glcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     style_sel,
  input  logic     a0,
  input  logic     e_rd,
  input  logic     rw_wr,
  input  logic [7:0] din,
  output logic     evt_valid,
  output bus_evt_t evt,
  output logic     rd_active
);

  logic style68_q;
  always_ff @(posedge clk)
    if (!rst_n) style68_q <= style_sel;

  logic [SYNC_STAGES:0] e_pipe, w_pipe;
  assign e_pipe[0] = e_rd;
  assign w_pipe[0] = rw_wr;

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    logic e_q, w_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        e_q <= 1'b0;
        w_q <= 1'b0;
      end else begin
        e_q <= e_pipe[g-1];
        w_q <= w_pipe[g-1];
      end
    assign e_pipe[g] = e_q;
    assign w_pipe[g] = w_q;
  end

  logic e_s, w_s, act_now, rd_now;
  assign e_s = e_pipe[SYNC_STAGES];
  assign w_s = w_pipe[SYNC_STAGES];
  assign act_now = style68_q ? e_s : (~e_s | ~w_s);
  assign rd_now  = style68_q ? w_s : ~e_s;

  logic act_prev_q, armed_q;
  logic hold_rd_q, hold_a0_q;
  logic [7:0] hold_val_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      hold_rd_q  <= 1'b0;
      hold_a0_q  <= 1'b0;
      hold_val_q <= '0;
    end else begin
      act_prev_q <= act_now;
      if (!act_now) armed_q <= 1'b1;
      if (act_now) begin
        hold_rd_q  <= rd_now;
        hold_a0_q  <= a0;
        hold_val_q <= din;
      end
    end

  assign evt_valid = armed_q & act_prev_q & ~act_now;
  assign evt       = '{rd: hold_rd_q, data: hold_a0_q, val: hold_val_q};
  assign rd_active = armed_q & act_now & rd_now;

endmodule

// File: rtl/glcd_cmd_regs.sv
module glcd_cmd_regs
  import glcd_pkg::*;
#(
  parameter int COLS        = 80,
  parameter int PAGES       = 4,
  parameter int LINES       = 32,
  parameter int BUSY_CYCLES = 16,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int LINE_W = $clog2(LINES),
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  bus_evt_t          evt,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] page,
  output logic [LINE_W-1:0] start_line,
  output logic              disp_off,
  output logic              seg_rev,
  output logic              static_on,
  output logic              duty32,
  output logic              rmw_on,
  output logic              busy,
  output logic              rst_win,
  output logic              acc_valid,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [7:0]        acc_wdata
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [COL_W-1:0]  COL_LAST = COL_W'(COLS - 1);
  localparam logic [BUSY_W-1:0] BUSY_LD  = BUSY_W'(BUSY_CYCLES);

  logic [COL_W-1:0]  col_q;
  logic [PAGE_W-1:0] page_q;
  logic [LINE_W-1:0] line_q;
  logic off_q, seg_q, stat_q, duty_q, rmw_q, rst_win_q;
  logic [BUSY_W-1:0] busy_q;

  op_kind_e kind;
  logic [COL_W-1:0] col_imm, col_set;
  logic data_evt, instr_evt, col_step;

  assign busy      = (busy_q != '0);
  assign data_evt  = evt_valid & evt.data;
  assign instr_evt = evt_valid & ~evt.data & ~evt.rd & ~busy;
  assign kind      = decode_op(evt.val);
  assign col_imm   = evt.val[COL_W-1:0];
  assign col_set   = (col_imm > COL_LAST) ? COL_LAST : col_imm;
  assign col_step  = data_evt & (~evt.rd | ~rmw_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      col_q     <= '0;
      page_q    <= '0;
      line_q    <= '0;
      off_q     <= 1'b1;
      seg_q     <= 1'b0;
      stat_q    <= 1'b0;
      duty_q    <= 1'b0;
      rmw_q     <= 1'b0;
      busy_q    <= BUSY_LD;
      rst_win_q <= 1'b1;
    end else begin
      if (data_evt)  busy_q <= BUSY_LD;
      else if (busy) busy_q <= busy_q - BUSY_W'(1);
      if (!busy) rst_win_q <= 1'b0;
      if (col_step) col_q <= (col_q == COL_LAST) ? '0 : col_q + COL_W'(1);
      if (instr_evt) begin
        case (kind)
          K_COL:    col_q  <= col_set;
          K_PAGE:   page_q <= evt.val[PAGE_W-1:0];
          K_LINE:   line_q <= evt.val[LINE_W-1:0];
          K_DISP:   off_q  <= ~evt.val[0];
          K_SEG:    seg_q  <= evt.val[0];
          K_STATIC: stat_q <= evt.val[0];
          K_DUTY:   duty_q <= evt.val[0];
          K_RMW:    rmw_q  <= 1'b1;
          K_END:    rmw_q  <= 1'b0;
          K_RESET: begin
            line_q <= '0;
            page_q <= '0;
            col_q  <= '0;
          end
          default: ;
        endcase
      end
    end

  assign col        = col_q;
  assign page       = page_q;
  assign start_line = line_q;
  assign disp_off   = off_q;
  assign seg_rev    = seg_q;
  assign static_on  = stat_q;
  assign duty32     = duty_q;
  assign rmw_on     = rmw_q;
  assign rst_win    = rst_win_q;

  assign acc_valid = data_evt;
  assign acc_wr    = ~evt.rd;
  assign acc_addr  = {page_q, col_q};
  assign acc_wdata = evt.val;

endmodule

// File: rtl/glcd_ram_port.sv
module glcd_ram_port #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [7:0]        rd_latch
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      pend_q    <= 1'b0;
      rd_latch  <= '0;
    end else begin
      ram_en <= acc_valid;
      ram_we <= acc_valid & acc_wr;
      if (acc_valid) begin
        ram_addr  <= acc_addr;
        ram_wdata <= acc_wdata;
      end
      pend_q <= ram_en & ~ram_we;
      if (pend_q) rd_latch <= ram_rdata;
    end

endmodule

// File: rtl/glcd_lcd_ctrl.sv
module glcd_lcd_ctrl
  import glcd_pkg::*;
#(
  parameter int COLS        = 80,
  parameter int PAGES       = 4,
  parameter int LINES       = 32,
  parameter int BUSY_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int LINE_W = $clog2(LINES),
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style_sel,
  input  logic              bus_a0,
  input  logic              bus_e_rd,
  input  logic              bus_rw_wr,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  output logic              bus_dout_en,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              lcd_off,
  output logic [LINE_W-1:0] lcd_start_line,
  output logic              lcd_seg_rev,
  output logic              lcd_static,
  output logic              lcd_duty32
);

  logic     evt_valid;
  bus_evt_t evt;
  logic     rd_active;

  logic [COL_W-1:0]  col_w;
  logic [PAGE_W-1:0] page_w;
  logic              rmw_w, busy_w, rst_win_w;
  logic              acc_valid, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [7:0]        acc_wdata, rd_latch;
  logic [7:0]        status_b;

  glcd_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .style_sel (style_sel),
    .a0        (bus_a0),
    .e_rd      (bus_e_rd),
    .rw_wr     (bus_rw_wr),
    .din       (bus_din),
    .evt_valid (evt_valid),
    .evt       (evt),
    .rd_active (rd_active)
  );

  glcd_cmd_regs #(
    .COLS(COLS), .PAGES(PAGES), .LINES(LINES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt        (evt),
    .col        (col_w),
    .page       (page_w),
    .start_line (lcd_start_line),
    .disp_off   (lcd_off),
    .seg_rev    (lcd_seg_rev),
    .static_on  (lcd_static),
    .duty32     (lcd_duty32),
    .rmw_on     (rmw_w),
    .busy       (busy_w),
    .rst_win    (rst_win_w),
    .acc_valid  (acc_valid),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata)
  );

  glcd_ram_port #(.ADDR_W(ADDR_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .ram_rdata (ram_rdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .rd_latch  (rd_latch)
  );

  assign status_b    = {busy_w, lcd_seg_rev, lcd_off, rst_win_w, 4'b0000};
  assign bus_dout_en = rd_active;
  assign bus_dout    = rd_active ? (bus_a0 ? rd_latch : status_b) : 8'h00;

endmodule

// File: rtl/glcd_lcd_ctrl_chk.sv
module glcd_lcd_ctrl_chk #(
  parameter int COLS   = 80,
  parameter int COL_W  = 7,
  parameter int PAGE_W = 2,
  parameter int CFG_W  = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ev_valid,
  input logic                    ev_rd,
  input logic                    ev_data,
  input logic                    busy,
  input logic                    rmw,
  input logic                    ram_en,
  input logic                    ram_we,
  input logic [PAGE_W+COL_W-1:0] ram_addr,
  input logic [COL_W-1:0]        col,
  input logic [PAGE_W-1:0]       page,
  input logic [CFG_W-1:0]        cfg
);

  localparam logic [COL_W-1:0] LAST = COL_W'(COLS - 1);

  a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ram_addr[COL_W-1:0] <= LAST);

  a_r5_wrap_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_data && !ev_rd && col == LAST) |=> (col == '0 && $stable(page)));

  a_r6_rmw_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_data && ev_rd && rmw) |=> $stable(col));

  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_data && !ev_rd && busy) |=> ($stable(col) && $stable(page) && $stable(cfg) && $stable(rmw)));

  a_r4_write_is_access: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> !ram_en);

endmodule

bind glcd_lcd_ctrl glcd_lcd_ctrl_chk #(
  .COLS(COLS), .COL_W(COL_W), .PAGE_W(PAGE_W), .CFG_W(LINE_W + 4)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_valid (evt_valid),
  .ev_rd    (evt.rd),
  .ev_data  (evt.data),
  .busy     (busy_w),
  .rmw      (rmw_w),
  .ram_en   (ram_en),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .col      (col_w),
  .page     (page_w),
  .cfg      ({lcd_off, lcd_start_line, lcd_seg_rev, lcd_static, lcd_duty32})
);

// File: tb/test_glcd_lcd_ctrl.sv
module test_glcd_lcd_ctrl;

  logic clk = 1'b0;
  always #10ns clk = ~clk;

  logic       rst_n = 1'b0, style_sel = 1'b1;
  logic       bus_a0 = 1'b0, bus_e_rd = 1'b0, bus_rw_wr = 1'b1;
  logic [7:0] bus_din = '0, bus_dout, ram_wdata, ram_rdata;
  logic       bus_dout_en, ram_en, ram_we;
  logic [8:0] ram_addr;
  logic       lcd_off, lcd_seg_rev, lcd_static, lcd_duty32;
  logic [4:0] lcd_start_line;
  logic       mode68 = 1'b1;

  int n_run = 0, n_fail = 0;

  glcd_lcd_ctrl i_glcd_lcd_ctrl (
    .clk(clk), .rst_n(rst_n), .style_sel(style_sel),
    .bus_a0(bus_a0), .bus_e_rd(bus_e_rd), .bus_rw_wr(bus_rw_wr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .lcd_off(lcd_off), .lcd_start_line(lcd_start_line),
    .lcd_seg_rev(lcd_seg_rev), .lcd_static(lcd_static), .lcd_duty32(lcd_duty32)
  );

  // single-port memory model, one clock read latency
  logic [7:0] mem [512];
  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    ram_rdata = 8'h00;
  end
  always @(posedge clk)
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end

  function automatic logic [8:0] cfg_now();
    return {lcd_off, lcd_start_line, lcd_seg_rev, lcd_static, lcd_duty32};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic do_reset(input logic style);
    rst_n     = 1'b0;
    style_sel = style;
    mode68    = style;
    bus_e_rd  = style ? 1'b0 : 1'b1;
    bus_rw_wr = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_op(input logic rd, input logic a0, input logic [7:0] d,
                        input int gap, output logic [7:0] got);
    @(negedge clk);
    bus_a0  = a0;
    bus_din = d;
    if (mode68) bus_rw_wr = rd;
    @(negedge clk);
    if (mode68) bus_e_rd = 1'b1;
    else if (rd) bus_e_rd = 1'b0;
    else bus_rw_wr = 1'b0;
    repeat (5) @(negedge clk);
    got = bus_dout;
    if (mode68) bus_e_rd = 1'b0;
    else begin
      bus_e_rd  = 1'b1;
      bus_rw_wr = 1'b1;
    end
    repeat (gap) @(negedge clk);
  endtask

  // vector: {kind[2], a0, data[8], expect[16], req[4]}
  // kind 0 write, 1 read and compare, 2 compare panel config, 3 discarded read
  function automatic logic [30:0] vw(input logic a0, input logic [7:0] d, input logic [3:0] r);
    return {2'd0, a0, d, 16'h0000, r};
  endfunction
  function automatic logic [30:0] vr(input logic a0, input logic [7:0] e, input logic [3:0] r);
    return {2'd1, a0, 8'h00, 8'h00, e, r};
  endfunction
  function automatic logic [30:0] vd();
    return {2'd3, 1'b1, 8'h00, 16'h0000, 4'd4};
  endfunction
  function automatic logic [30:0] vc(input logic [8:0] e, input logic [3:0] r);
    return {2'd2, 1'b0, 8'h00, 7'h00, e, r};
  endfunction

  localparam int NV = 45;
  localparam logic [30:0] VEC [NV] = '{
    vr(1'b0, 8'h20, 4'd7),     // R7 settled status: display off only
    vc(9'h100, 4'd11),         // R11 reset panel config
    vw(1'b0, 8'hAF, 4'd8),     // R8 display on
    vr(1'b0, 8'h00, 4'd2),     // R2 a0 low reads status
    vw(1'b0, 8'hB9, 4'd3),     // R3 page 1
    vw(1'b0, 8'h05, 4'd3),     // R3 column 5
    vw(1'b1, 8'h3C, 4'd4),     // R4 write {1,5}
    vw(1'b1, 8'hA5, 4'd4),     // R4 write {1,6}
    vw(1'b0, 8'h05, 4'd3),
    vr(1'b1, 8'h00, 4'd4),     // R4 first read is stale
    vr(1'b1, 8'h3C, 4'd4),
    vr(1'b1, 8'hA5, 4'd4),
    vw(1'b0, 8'h7F, 4'd3),     // R3 clamps to 79
    vw(1'b1, 8'h11, 4'd5),     // at column 79
    vw(1'b1, 8'h22, 4'd5),     // R5 wrapped to column 0, same page
    vw(1'b0, 8'h4F, 4'd3),
    vd(),
    vr(1'b1, 8'h11, 4'd3),
    vr(1'b1, 8'h22, 4'd5),
    vw(1'b0, 8'h0A, 4'd6),
    vw(1'b0, 8'hE0, 4'd6),     // R6 enter read-modify-write
    vd(),
    vw(1'b1, 8'h77, 4'd6),
    vw(1'b1, 8'h88, 4'd6),
    vw(1'b0, 8'hEE, 4'd6),     // R6 leave
    vw(1'b0, 8'h0A, 4'd6),
    vd(),
    vr(1'b1, 8'h77, 4'd6),
    vr(1'b1, 8'h88, 4'd6),
    vw(1'b0, 8'hA1, 4'd8),
    vw(1'b0, 8'hAE, 4'd8),
    vr(1'b0, 8'h60, 4'd7),     // R7 reverse + off
    vw(1'b0, 8'hD5, 4'd8),     // start line 21
    vw(1'b0, 8'hA5, 4'd8),
    vw(1'b0, 8'hA9, 4'd8),
    vc(9'h1AF, 4'd8),
    vw(1'b0, 8'hBA, 4'd10),
    vw(1'b0, 8'h14, 4'd10),
    vw(1'b0, 8'hE2, 4'd10),    // R10 home
    vc(9'h107, 4'd10),
    vw(1'b1, 8'h99, 4'd10),    // lands at {0,0}
    vw(1'b0, 8'hB8, 4'd10),
    vw(1'b0, 8'h00, 4'd10),
    vd(),
    vr(1'b1, 8'h99, 4'd10)
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] got;
    do_reset(1'b1);
    // R11 and R9: busy and reset window right after reset
    bus_op(1'b1, 1'b0, 8'h00, 40, got);
    check("R11", {8'h00, got}, 16'h00B0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [15:0] exp;
      kind = VEC[i][30:29];
      exp  = VEC[i][19:4];
      case (kind)
        2'd0: bus_op(1'b0, VEC[i][28], VEC[i][27:20], 24, got);
        2'd1: begin
          bus_op(1'b1, VEC[i][28], 8'h00, 24, got);
          check($sformatf("R%0d", VEC[i][3:0]), {8'h00, got}, exp);
        end
        2'd2: check($sformatf("R%0d", VEC[i][3:0]), {7'h00, cfg_now()}, exp);
        default: bus_op(1'b1, 1'b1, 8'h00, 24, got);
      endcase
    end

    // R9: instruction right after a data write is dropped
    bus_op(1'b0, 1'b0, 8'h1E, 24, got);
    bus_op(1'b0, 1'b1, 8'h5A, 2, got);
    bus_op(1'b0, 1'b0, 8'h02, 2, got);
    bus_op(1'b1, 1'b0, 8'h00, 24, got);
    check("R9", {8'h00, got}, 16'h00E0);
    bus_op(1'b0, 1'b1, 8'h6B, 24, got);
    bus_op(1'b0, 1'b0, 8'h1E, 24, got);
    bus_op(1'b1, 1'b1, 8'h00, 24, got);
    bus_op(1'b1, 1'b1, 8'h00, 24, got);
    check("R9", {8'h00, got}, 16'h005A);
    bus_op(1'b1, 1'b1, 8'h00, 24, got);
    check("R9", {8'h00, got}, 16'h006B);

    // R1: separate strobe style chosen at reset
    do_reset(1'b0);
    repeat (4) @(negedge clk);
    bus_op(1'b1, 1'b0, 8'h00, 30, got);
    check("R1", {8'h00, got}, 16'h00B0);
    check("R11", {7'h00, cfg_now()}, 16'h0100);
    bus_op(1'b0, 1'b0, 8'h03, 24, got);
    bus_op(1'b0, 1'b1, 8'hC3, 24, got);
    bus_op(1'b0, 1'b0, 8'h03, 24, got);
    bus_op(1'b1, 1'b1, 8'h00, 24, got);
    bus_op(1'b1, 1'b1, 8'h00, 24, got);
    check("R1", {8'h00, got}, 16'h00C3);
    bus_op(1'b1, 1'b0, 8'h00, 24, got);
    check("R1", {8'h00, got}, 16'h0020);

    report();
    $finish;
  end

endmodule